// File: doc/BRIEF.md
# Prescaled Reference-Compare Timer

A memory-mapped up-counter for periodic or one-shot timing. A count-enable pulse comes from a two-stage divider: a fixed divide-by-16 stage that can be switched in or out, then a programmable prescaler that divides by an 8-bit field plus one. Each pulse advances the count by one. When a pulse arrives while the count equals the programmed reference value, a sticky reference flag is set. The count then either goes back to zero (restart mode) or keeps counting and wraps at its full range.

Software drives the block through a small register bus. The bus has an address, a write strobe, write data and combinational read data. Through it, software sets the mode and the reference value, stores a capture word, loads or reads the live count, and clears event flags by writing ones to them. A single level interrupt is high while the reference flag is set and the interrupt enable in the mode word is on.

Top module: `ref_timer`

## Requirements
- R1: After reset, every register (mode, reference, capture, count, event) reads zero and `irq` is low.
- R2: Offset 0x00 reads the mode word, 0x04 the reference, 0x08 the capture word and 0x0C the live count. Offset 0x11 returns the event flags in bits [1:0]: bit 1 is the reference flag and bit 0 is the capture flag. Every other offset reads zero.
- R3: The count advances only when mode bit 0 is 1 and mode bits [2:1] are 1 (system clock) or 2 (system clock divided by 16). With bit 0 clear, or with bits [2:1] equal to 0 or 3, the count holds.
- R4: With mode bits [15:8] = P, the count advances once every (P+1) clock cycles for source 1, and once every 16*(P+1) clock cycles for source 2. The first advance comes that many cycles after the write that started the timer.
- R5: When a count-enable pulse arrives while the count equals the reference, event bit 1 is set. If mode bit 3 is 1 the count goes to zero; otherwise it goes on to count+1.
- R6: Any write to the mode register or to the reference register sets the count to zero and restarts the divider chain.
- R7: A mode write whose data has bit 0 clear, while the stored mode bit 0 is 1, clears the reference register. The mode register takes the written value.
- R8: Writing to offset 0x11 clears each event bit whose data bit is 1 and leaves the others unchanged. A reference match in the same cycle wins over the clear.
- R9: `irq` is high exactly when mode bit 4 and event bit 1 are both 1.
- R10: A write to offset 0x0C loads the count directly and restarts the divider chain. The count wraps from 0xFFFF to 0, so a loaded value above the reference passes through the wrap before it can match.
- R11: Mode bits [7:5] are stored and read back but do not change counting, matching or the interrupt.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_addr | input | ADDR_W (5) | Register byte offset |
| bus_wr | input | 1 | Write strobe, one cycle per write |
| bus_wdata | input | 16 | Write data |
| bus_rdata | output | 16 | Read data for `bus_addr`, combinational |
| irq | output | 1 | Level interrupt |

## Verification
The assertions assume that `bus_wr` is a single-cycle strobe with a stable address and data. They also assume that a mode write always comes with a restart of the divider, so a source change never takes effect mid-period. The bench drives every write for exactly one clock edge from the falling edge and reads only while the strobe is low. It changes the clock source only through a mode write. The boundary checks sample the count one cycle before and one cycle at the match pulse, where the expected values follow from the division ratio alone.

// File: rtl/rtm_pkg.sv
package rtm_pkg;

   localparam int unsigned PRE_W  = 8;
   localparam int unsigned WORD_W = 16;

   typedef enum logic [1:0] {
      SRC_OFF0 = 2'd0,
      SRC_SYS  = 2'd1,
      SRC_SLOW = 2'd2,
      SRC_OFF3 = 2'd3
   } src_e;

   // Field order matches the software-visible bit positions.
   typedef struct packed {
      logic [PRE_W-1:0] pre;       // [15:8]
      logic [1:0]       edge_sel;  // [7:6] stored only
      logic             out_mode;  // [5]   stored only
      logic             irq_en;    // [4]
      logic             restart;   // [3]
      src_e             src;       // [2:1]
      logic             enable;    // [0]
   } mode_t;

endpackage

// File: rtl/rtm_prescaler.sv
module rtm_prescaler #(
   parameter int unsigned PRE_W    = 8,
   parameter int unsigned SLOW_DIV = 16
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             restart,
   input  logic             run,
   input  logic             slow,
   input  logic [PRE_W-1:0] pre,
   output logic             tick
);

   logic             base_en;
   logic [PRE_W-1:0] pcnt_q;

   if (SLOW_DIV < 1) begin : g_bad_div
      $error("rtm_prescaler: SLOW_DIV must be at least 1");
   end

   if (SLOW_DIV == 1) begin : g_no_slow
      assign base_en = 1'b1;
   end else begin : g_slow
      localparam int unsigned SW = $clog2(SLOW_DIV);
      localparam logic [SW-1:0] S_LAST = SW'(SLOW_DIV - 1);
      logic [SW-1:0] s_q;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)              s_q <= '0;
         else if (restart)        s_q <= '0;
         else if (run && slow)    s_q <= (s_q == S_LAST) ? '0 : s_q + 1'b1;
      end
      assign base_en = slow ? (s_q == S_LAST) : 1'b1;
   end

   assign tick = run && base_en && (pcnt_q == pre);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)               pcnt_q <= '0;
      else if (restart)         pcnt_q <= '0;
      else if (run && base_en)  pcnt_q <= (pcnt_q == pre) ? '0 : pcnt_q + 1'b1;
   end

   // R3: no count-enable pulse while the timer is not running
   p_tick_needs_run_r3: assert property (@(posedge clk) disable iff (!rst_n)
      !run |-> !tick);

   // R4: the prescale counter restarts from zero after a restart
   p_restart_clears_r4: assert property (@(posedge clk) disable iff (!rst_n)
      restart |=> pcnt_q == '0);

endmodule

// File: rtl/rtm_counter.sv
module rtm_counter #(
   parameter int unsigned CNT_W = 16
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             restart,
   input  logic             load,
   input  logic [CNT_W-1:0] load_val,
   input  logic             tick,
   input  logic [CNT_W-1:0] ref_val,
   input  logic             wrap_on_ref,
   output logic [CNT_W-1:0] count,
   output logic             hit
);

   logic match;

   assign match = (count == ref_val);
   assign hit   = tick && !restart && !load && match;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                    count <= '0;
      else if (restart)              count <= '0;
      else if (load)                 count <= load_val;
      else if (tick) begin
         if (match && wrap_on_ref)   count <= '0;
         else                        count <= count + 1'b1;
      end
   end

   // R6: a restart leaves the count at zero
   p_restart_zero_r6: assert property (@(posedge clk) disable iff (!rst_n)
      restart |=> count == '0);

   // R3: with no pulse, load or restart the count holds
   p_idle_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (!restart && !load && !tick) |=> $stable(count));

   // R10: full-range wrap when no reference restart applies
   p_wrap_r10: assert property (@(posedge clk) disable iff (!rst_n)
      (tick && !restart && !load && (&count) && !(match && wrap_on_ref))
      |=> count == '0);

   // R10: a load takes the written value
   p_load_r10: assert property (@(posedge clk) disable iff (!rst_n)
      (load && !restart) |=> count == $past(load_val));

endmodule

// File: rtl/ref_timer.sv
module ref_timer #(
   parameter int unsigned CNT_W    = 16,
   parameter int unsigned SLOW_DIV = 16,
   parameter int unsigned ADDR_W   = 5
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [ADDR_W-1:0] bus_addr,
   input  logic              bus_wr,
   input  logic [15:0]       bus_wdata,
   output logic [15:0]       bus_rdata,
   output logic              irq
);
   import rtm_pkg::*;

   localparam logic [ADDR_W-1:0] OFS_MODE = ADDR_W'(8'h00);
   localparam logic [ADDR_W-1:0] OFS_REF  = ADDR_W'(8'h04);
   localparam logic [ADDR_W-1:0] OFS_CAP  = ADDR_W'(8'h08);
   localparam logic [ADDR_W-1:0] OFS_CNT  = ADDR_W'(8'h0C);
   localparam logic [ADDR_W-1:0] OFS_EV   = ADDR_W'(8'h11);

   if (CNT_W < 4 || CNT_W > WORD_W) begin : g_bad_cnt
      $error("ref_timer: CNT_W must lie in 4..16");
   end
   if (ADDR_W < 5) begin : g_bad_addr
      $error("ref_timer: ADDR_W must be at least 5");
   end

   mode_t            mode_q;
   logic [CNT_W-1:0] ref_q;
   logic [15:0]      cap_q;
   logic [1:0]       ev_q;
   logic [CNT_W-1:0] count;
   logic             hit, tick, run, slow;
   logic             wr_mode, wr_ref, wr_cap, wr_cnt, wr_ev;
   logic             restart;

   assign wr_mode = bus_wr && (bus_addr == OFS_MODE);
   assign wr_ref  = bus_wr && (bus_addr == OFS_REF);
   assign wr_cap  = bus_wr && (bus_addr == OFS_CAP);
   assign wr_cnt  = bus_wr && (bus_addr == OFS_CNT);
   assign wr_ev   = bus_wr && (bus_addr == OFS_EV);
   assign restart = wr_mode || wr_ref;

   assign run  = mode_q.enable && (mode_q.src == SRC_SYS || mode_q.src == SRC_SLOW);
   assign slow = (mode_q.src == SRC_SLOW);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         mode_q <= '0;
         ref_q  <= '0;
         cap_q  <= '0;
      end else begin
         if (wr_mode) mode_q <= mode_t'(bus_wdata);
         if (wr_mode && mode_q.enable && !bus_wdata[0]) ref_q <= '0;
         else if (wr_ref)                               ref_q <= bus_wdata[CNT_W-1:0];
         if (wr_cap)  cap_q <= bus_wdata;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) ev_q <= '0;
      else        ev_q <= (ev_q & ~({2{wr_ev}} & bus_wdata[1:0])) | {hit, 1'b0};
   end

   rtm_prescaler #(.PRE_W(PRE_W), .SLOW_DIV(SLOW_DIV)) i_pre (
      .clk     (clk),
      .rst_n   (rst_n),
      .restart (restart || wr_cnt),
      .run     (run),
      .slow    (slow),
      .pre     (mode_q.pre),
      .tick    (tick)
   );

   rtm_counter #(.CNT_W(CNT_W)) i_cnt (
      .clk         (clk),
      .rst_n       (rst_n),
      .restart     (restart),
      .load        (wr_cnt),
      .load_val    (bus_wdata[CNT_W-1:0]),
      .tick        (tick),
      .ref_val     (ref_q),
      .wrap_on_ref (mode_q.restart),
      .count       (count),
      .hit         (hit)
   );

   always_comb begin
      case (bus_addr)
         OFS_MODE: bus_rdata = mode_q;
         OFS_REF:  bus_rdata = 16'(ref_q);
         OFS_CAP:  bus_rdata = cap_q;
         OFS_CNT:  bus_rdata = 16'(count);
         OFS_EV:   bus_rdata = {14'd0, ev_q};
         default:  bus_rdata = '0;
      endcase
   end

   assign irq = mode_q.irq_en && ev_q[1];

   // R5: a match pulse always leaves the reference flag set
   p_hit_sets_flag_r5: assert property (@(posedge clk) disable iff (!rst_n)
      hit |=> ev_q[1]);

   // R8: writing one clears the flag unless a match arrives together
   p_w1c_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_ev && bus_wdata[1] && !hit) |=> !ev_q[1]);

   // R7: stopping a running timer clears the reference
   p_stop_clears_ref_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_mode && mode_q.enable && !bus_wdata[0]) |=> ref_q == '0);

   // R9: the interrupt can only rise with the flag set and enabled
   p_irq_rise_r9: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(irq) |-> (ev_q[1] && mode_q.irq_en));

endmodule

// File: tb/test_ref_timer.sv
module test_ref_timer;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [4:0]  bus_addr = '0;
   logic        bus_wr = 1'b0;
   logic [15:0] bus_wdata = '0;
   logic [15:0] bus_rdata;
   logic        irq;

   int n_chk = 0;
   int n_bad = 0;
   bit done  = 1'b0;

   always #2 clk = ~clk;

   ref_timer i_ref_timer (
      .clk       (clk),
      .rst_n     (rst_n),
      .bus_addr  (bus_addr),
      .bus_wr    (bus_wr),
      .bus_wdata (bus_wdata),
      .bus_rdata (bus_rdata),
      .irq       (irq)
   );

   task automatic chk(input string req, input int got, input int exp);
      n_chk++;
      if (got != exp) begin
         n_bad++;
         $display("FAIL %s: got 0x%0h expected 0x%0h", req, got, exp);
      end
   endtask

   task automatic wr_reg(input logic [4:0] a, input logic [15:0] d);
      @(negedge clk);
      bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
      @(negedge clk);
      bus_wr = 1'b0;
   endtask

   task automatic rd_reg(input logic [4:0] a, output int v);
      bus_addr = a;
      #0.5;
      v = int'(bus_rdata);
   endtask

   task automatic idle(input int n);
      repeat (n) @(negedge clk);
   endtask

   // Arithmetic model of ticks applied from a start count
   function automatic void model(input int start, input int r, input bit rs,
                                 input int ticks, output int c, output bit ev);
      c = start; ev = 1'b0;
      for (int t = 0; t < ticks; t++) begin
         if (c == r) begin
            ev = 1'b1;
            c = rs ? 0 : ((c + 1) & 16'hFFFF);
         end else begin
            c = (c + 1) & 16'hFFFF;
         end
      end
   endfunction

   task automatic setup(input int r);
      wr_reg(5'h00, 16'h0000);
      wr_reg(5'h04, 16'(r));
      wr_reg(5'h11, 16'h0003);
   endtask

   initial begin
      int v, c;
      bit ev;
      #9;
      rst_n = 1'b1;
      @(negedge clk);

      // R1: reset state
      rd_reg(5'h00, v); chk("R1 mode", v, 0);
      rd_reg(5'h04, v); chk("R1 ref", v, 0);
      rd_reg(5'h08, v); chk("R1 capture", v, 0);
      rd_reg(5'h0C, v); chk("R1 count", v, 0);
      rd_reg(5'h11, v); chk("R1 event", v, 0);
      chk("R1 irq", int'(irq), 0);

      // R2: readback and unmapped offsets
      wr_reg(5'h08, 16'hBEEF);
      rd_reg(5'h08, v); chk("R2 capture", v, 16'hBEEF);
      wr_reg(5'h04, 16'h1234);
      rd_reg(5'h04, v); chk("R2 ref", v, 16'h1234);
      wr_reg(5'h00, 16'h5AE4);
      rd_reg(5'h00, v); chk("R2 R11 mode", v, 16'h5AE4);
      foreach (v_offs[i]) begin
         rd_reg(v_offs[i], v); chk("R2 unmapped", v, 0);
      end

      // R3: idle sources and disabled timer
      for (int s = 0; s < 4; s += 3) begin
         setup(2);
         wr_reg(5'h00, 16'(16'h0001 | (s << 1)));
         idle(40);
         rd_reg(5'h0C, v); chk("R3 idle source", v, 0);
      end
      setup(2);
      wr_reg(5'h00, 16'h0002);
      idle(40);
      rd_reg(5'h0C, v); chk("R3 disabled", v, 0);

      // R4 R5 R9 R11: sweep of source, prescale, reference and restart
      for (int src = 1; src <= 2; src++)
      for (int p = 0; p < 4; p++)
      for (int ri = 0; ri < 3; ri++)
      for (int rs = 0; rs < 2; rs++) begin
         int r, dv, md, ien;
         r   = (ri == 0) ? 0 : (ri == 1) ? 2 : 5;
         dv  = (p + 1) * ((src == 2) ? 16 : 1);
         ien = (p < 2) ? 1 : 0;
         md  = (p << 8) | ((p % 2 == 1) ? 16'h00E0 : 0) | (ien << 4) |
               (rs << 3) | (src << 1) | 1;
         setup(r);
         wr_reg(5'h00, 16'(md));
         idle(dv * r + dv - 1);
         rd_reg(5'h0C, v); chk("R4 count before match", v, r);
         rd_reg(5'h11, v); chk("R5 no flag before match", v, 0);
         idle(1);
         rd_reg(5'h0C, v); chk("R5 count after match", v, rs ? 0 : r + 1);
         rd_reg(5'h11, v); chk("R5 flag after match", v, 2);
         chk("R9 irq", int'(irq), ien);
      end

      // R8: write-one-to-clear, per bit
      wr_reg(5'h00, 16'h0000);
      setup(1);
      wr_reg(5'h00, 16'h0013);
      idle(4);
      chk("R9 irq set", int'(irq), 1);
      wr_reg(5'h00, 16'h0011);
      rd_reg(5'h11, v); chk("R8 flag survives mode write", v, 2);
      wr_reg(5'h00, 16'h0001);
      chk("R9 irq disabled", int'(irq), 0);
      wr_reg(5'h11, 16'h0001);
      rd_reg(5'h11, v); chk("R8 bit0 clear keeps bit1", v, 2);
      wr_reg(5'h11, 16'h0002);
      rd_reg(5'h11, v); chk("R8 bit1 cleared", v, 0);

      // R6: reference write restarts the count
      setup(100);
      wr_reg(5'h00, 16'h0003);
      idle(20);
      wr_reg(5'h04, 16'd100);
      idle(3);
      rd_reg(5'h0C, v); chk("R6 restart on ref write", v, 3);

      // R7: stopping clears reference, mode takes data
      wr_reg(5'h04, 16'd9);
      wr_reg(5'h00, 16'h0030);
      rd_reg(5'h04, v); chk("R7 ref cleared", v, 0);
      rd_reg(5'h00, v); chk("R7 mode written", v, 16'h0030);
      wr_reg(5'h04, 16'd9);
      wr_reg(5'h00, 16'h0000);
      rd_reg(5'h04, v); chk("R7 stopped->stopped keeps ref", v, 9);

      // R10: loads above reference and across the wrap
      setup(5);
      wr_reg(5'h00, 16'h0003);
      wr_reg(5'h0C, 16'd10);
      idle(7);
      model(10, 5, 1'b0, 7, c, ev);
      rd_reg(5'h0C, v); chk("R10 load above ref", v, c);
      rd_reg(5'h11, v); chk("R10 no match above ref", v, ev ? 2 : 0);
      setup(3);
      wr_reg(5'h00, 16'h0003);
      wr_reg(5'h0C, 16'hFFFD);
      idle(3);
      model(16'hFFFD, 3, 1'b0, 3, c, ev);
      rd_reg(5'h0C, v); chk("R10 wrap to zero", v, c);
      rd_reg(5'h11, v); chk("R10 no flag at wrap", v, ev ? 2 : 0);
      idle(4);
      model(16'hFFFD, 3, 1'b0, 7, c, ev);
      rd_reg(5'h0C, v); chk("R10 count after wrap", v, c);
      rd_reg(5'h11, v); chk("R10 match after wrap", v, ev ? 2 : 0);

      done = 1'b1;
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
   end

   logic [4:0] v_offs [4] = '{5'h01, 5'h10, 5'h14, 5'h1F};

   initial begin
      repeat (150000) @(posedge clk);
      if (!done) begin
         n_chk++;
         n_bad++;
         $display("FAIL watchdog: got timeout expected completion");
         $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
         $finish;
      end
   end

endmodule